// File: doc/BRIEF.md
# DSI Link Rate Calculator

This block works out the serial clock a DSI video-mode link needs, in kHz, from a panel's timing. The four horizontal regions (sync, back porch, active, front porch) are each turned into a byte count at the chosen pixel depth. The fixed packet header and footer bytes are added to give a line length. The line length is multiplied by the total line count and by the refresh rate to get bytes per second. That figure is split across the lanes and converted to kHz. End-of-transmission packets add bytes in a way that depends on the video mode.

A second mode skips the timing walk. It returns the pixel clock times the bits per pixel, divided by the lane count and rounded to nearest. A single pulse on the start input samples all inputs. One shift-and-add multiplier and one restoring divider are then reused over several steps. A one-cycle done pulse marks a new 32-bit result, and that result is held until the next operation completes.

Top module: `dsi_link_rate_calc`

## Requirements
- R1: Bits per pixel follow the 3-bit format code: code 1 gives 18, code 3 gives 16, and codes 0, 2 and 4 to 7 give 24.
- R2: Each horizontal region becomes ceil(pixels × bpp / 8) bytes, computed separately for sync, back porch, active and front porch.
- R3: A line is the sum of the four region byte counts plus 32 overhead bytes.
- R4: With video mode code 2 (burst) and the end-of-transmission enable high, 4 bytes are added to every line and the final kHz value is doubled.
- R5: Frame bytes are line bytes times the sum of the four vertical counts. With mode code 0 (sync pulses) or 1 (sync events) and the enable high, 4 bytes are added once per frame. Mode code 3 adds nothing.
- R6: In timing mode (simple_i low), the result is floor(floor(floor(refresh × frame bytes / lanes) × 8) / 1000), computed in 64-bit precision.
- R7: In simple mode (simple_i high), the result is (pclk_khz × bpp + floor(lanes/2)) / lanes, which rounds to nearest with halves going up.
- R8: A lane count of 0 is treated as 1.
- R9: Any result above 0xFFFFFFFF is reported as 0xFFFFFFFF.
- R10: busy_o rises the cycle after an accepted start. done_o is high for exactly one cycle, with busy_o low, when rate_khz_o takes its new value. rate_khz_o does not change at any other time.
- R11: A start pulse while busy_o is high is ignored, and the running computation finishes on the inputs sampled at the accepted start.
- R12: After reset, busy_o and done_o are low and rate_khz_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse; all inputs are sampled when it is accepted |
| simple_i | input | 1 | 1 selects the pixel-clock estimate, 0 selects the timing walk |
| fmt_i | input | 3 | Pixel format code |
| vmode_i | input | 2 | Video mode: 0 sync pulses, 1 sync events, 2 burst, 3 no padding |
| eotp_i | input | 1 | End-of-transmission packet enable |
| lanes_i | input | 3 | Lane count, 1 to 4 (0 is treated as 1) |
| refresh_i | input | 8 | Frames per second |
| pclk_khz_i | input | 32 | Pixel clock in kHz, used in simple mode |
| h_act_i | input | 16 | Horizontal active pixels |
| h_fp_i | input | 16 | Horizontal front porch pixels |
| h_sync_i | input | 16 | Horizontal sync pixels |
| h_bp_i | input | 16 | Horizontal back porch pixels |
| v_act_i | input | 16 | Vertical active lines |
| v_fp_i | input | 16 | Vertical front porch lines |
| v_sync_i | input | 16 | Vertical sync lines |
| v_bp_i | input | 16 | Vertical back porch lines |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse marking a new result |
| rate_khz_o | output | 32 | Link clock in kHz, saturated |

## Verification
A bad internal state shows up only in the one result word, and only when done_o pulses, roughly 100 to 200 cycles after start. A wrong region byte count or a misplaced padding rule skews the value by a few bytes per line or per frame. After the divisions that error may be only a few kHz, so small, exact timings are used alongside large random ones. A stuck sequencer shows at the ports as busy_o that never drops. A start that leaks through mid-run shows as a result computed from the second input set.

// File: rtl/dlr_pkg.sv
// Shared constants, encodings and helper functions for the link rate calculator.
// Assumes the result is 32 bits and all intermediates fit in 64 bits.
package dlr_pkg;

    localparam int RES_W = 32;
    localparam int WIDE_W = 64;

    // 4 sync-start + 4 sync-end + 6 for each of four region packets
    localparam logic [5:0] LINE_OVH_BYTES = 6'd32;
    localparam logic [2:0] EOT_PAD_BYTES  = 3'd4;

    typedef enum logic [2:0] {
        FMT_RGB24        = 3'd0,
        FMT_RGB18_PACKED = 3'd1,
        FMT_RGB18_LOOSE  = 3'd2,
        FMT_RGB16        = 3'd3
    } pix_fmt_e;

    typedef enum logic [1:0] {
        VM_SYNC_PULSE = 2'd0,
        VM_SYNC_EVENT = 2'd1,
        VM_BURST      = 2'd2,
        VM_PLAIN      = 2'd3
    } vid_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_RATE,
        ST_LANE,
        ST_KHZ,
        ST_PMUL,
        ST_PDIV
    } calc_st_e;

    // Bits per pixel for a format code; unknown codes take 24.
    function automatic logic [4:0] bpp_of(input logic [2:0] code);
        case (code)
            FMT_RGB18_PACKED: return 5'd18;
            FMT_RGB16:        return 5'd16;
            default:          return 5'd24;
        endcase
    endfunction

    // Clamp a wide value to the 32-bit result range.
    function automatic logic [RES_W-1:0] sat_to_res(input logic [WIDE_W-1:0] v);
        return (|v[WIDE_W-1:RES_W]) ? {RES_W{1'b1}} : v[RES_W-1:0];
    endfunction

endpackage

// File: rtl/dlr_line_bytes.sv
// Combinational line length: converts each horizontal region to whole bytes,
// adds the fixed packet overhead and the optional per-line end packet.
// Assumes bpp_i <= 24 and TW-bit pixel counts.
module dlr_line_bytes
    import dlr_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic [3:0][TW-1:0] px_i,
    input  logic [4:0]         bpp_i,
    input  logic               eot_line_i,
    output logic [TW+5:0]      bytes_o
);
    localparam int LW = TW + 6;
    localparam int PW = TW + 6;

    logic [3:0][LW-1:0] seg_bytes;

    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_seg
            logic [PW-1:0] bits_w;
            // round the region's bit count up to a byte boundary
            assign bits_w       = PW'(px_i[g]) * PW'(bpp_i) + PW'(7);
            assign seg_bytes[g] = LW'(bits_w >> 3);
        end
    endgenerate

    // sum regions, overhead and optional end packet
    always_comb begin
        bytes_o = LW'(LINE_OVH_BYTES);
        for (int i = 0; i < 4; i++) begin
            bytes_o = bytes_o + seg_bytes[i];
        end
        if (eot_line_i) begin
            bytes_o = bytes_o + LW'(EOT_PAD_BYTES);
        end
    end

endmodule

// File: rtl/dlr_seq_mul.sv
// Shift-and-add multiplier: one multiplier bit per cycle, BW cycles per product.
// Assumes start_i is only raised while busy_o is low; the product is truncated to AW bits.
module dlr_seq_mul #(
    parameter int AW = 64,
    parameter int BW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] prod_o
);
    localparam int CW = $clog2(BW + 1);

    logic [AW-1:0] mcand;
    logic [BW-1:0] mplier;
    logic [CW-1:0] cnt;

    // iterate one multiplier bit per cycle and accumulate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            prod_o <= '0;
            cnt    <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_o) begin
                mcand  <= a_i;
                mplier <= b_i;
                prod_o <= '0;
                cnt    <= CW'(BW);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (mplier[0]) begin
                    prod_o <= prod_o + mcand;
                end
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assert_mul_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/dlr_seq_div.sv
// Restoring divider: one quotient bit per cycle, NW cycles per quotient.
// Assumes a nonzero divisor and start_i only while busy_o is low.
module dlr_seq_div #(
    parameter int NW = 64,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [NW-1:0] quot_o
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem;
    logic [DW-1:0] dvs;
    logic [CW-1:0] cnt;
    logic [DW:0]   trial;

    // partial remainder with the next dividend bit shifted in
    always_comb trial = {rem, quot_o[NW-1]};

    // one subtract-or-keep step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem    <= '0;
            dvs    <= '0;
            quot_o <= '0;
            cnt    <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_o) begin
                quot_o <= num_i;
                rem    <= '0;
                dvs    <= den_i;
                cnt    <= CW'(NW);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (trial >= {1'b0, dvs}) begin
                    rem    <= DW'(trial - {1'b0, dvs});
                    quot_o <= {quot_o[NW-2:0], 1'b1};
                end else begin
                    rem    <= trial[DW-1:0];
                    quot_o <= {quot_o[NW-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assert_rem_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem < dvs));

    assert_nonzero_den_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |-> (den_i != '0));

endmodule

// File: rtl/dsi_link_rate_calc.sv
// Link clock calculator top: samples timing on start, then sequences one
// multiplier and one divider through either the timing walk or the pixel-clock
// estimate, and saturates the kHz result to 32 bits.
// Assumes the default widths keep every intermediate below 2^64.
module dsi_link_rate_calc
    import dlr_pkg::*;
#(
    parameter int TW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          simple_i,
    input  logic [2:0]    fmt_i,
    input  logic [1:0]    vmode_i,
    input  logic          eotp_i,
    input  logic [2:0]    lanes_i,
    input  logic [RW-1:0] refresh_i,
    input  logic [31:0]   pclk_khz_i,
    input  logic [TW-1:0] h_act_i,
    input  logic [TW-1:0] h_fp_i,
    input  logic [TW-1:0] h_sync_i,
    input  logic [TW-1:0] h_bp_i,
    input  logic [TW-1:0] v_act_i,
    input  logic [TW-1:0] v_fp_i,
    input  logic [TW-1:0] v_sync_i,
    input  logic [TW-1:0] v_bp_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [31:0]   rate_khz_o
);
    localparam int LW = TW + 6;
    localparam int VW = TW + 2;
    localparam int BW = 32;

    calc_st_e            state;
    logic [4:0]          bpp_w;
    logic [LW-1:0]       line_bytes;
    logic [VW-1:0]       vlines;
    logic                line_pad_w;

    logic [2:0]          lanes_q;
    logic [RW-1:0]       refresh_q;
    logic                simple_q;
    logic                frame_pad_q;
    logic                dbl_q;

    logic                mul_go, mul_busy, mul_done;
    logic [WIDE_W-1:0]   mul_a, mul_p;
    logic [BW-1:0]       mul_b;
    logic                div_go, div_busy, div_done;
    logic [WIDE_W-1:0]   div_n, div_q;
    logic [BW-1:0]       div_d;

    assign bpp_w      = bpp_of(fmt_i);
    assign line_pad_w = eotp_i && (vmode_i == VM_BURST);
    assign busy_o     = (state != ST_IDLE);

    // total line count of a frame
    always_comb vlines = VW'(v_act_i) + VW'(v_fp_i) + VW'(v_sync_i) + VW'(v_bp_i);

    dlr_line_bytes #(.TW(TW)) u_line (
        .px_i       ({h_sync_i, h_bp_i, h_act_i, h_fp_i}),
        .bpp_i      (bpp_w),
        .eot_line_i (line_pad_w),
        .bytes_o    (line_bytes)
    );

    dlr_seq_mul #(.AW(WIDE_W), .BW(BW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mul_go),
        .a_i     (mul_a),
        .b_i     (mul_b),
        .busy_o  (mul_busy),
        .done_o  (mul_done),
        .prod_o  (mul_p)
    );

    dlr_seq_div #(.NW(WIDE_W), .DW(BW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_go),
        .num_i   (div_n),
        .den_i   (div_d),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quot_o  (div_q)
    );

    // sequence the arithmetic steps and publish the saturated result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            mul_go      <= 1'b0;
            div_go      <= 1'b0;
            mul_a       <= '0;
            mul_b       <= '0;
            div_n       <= '0;
            div_d       <= '0;
            lanes_q     <= 3'd1;
            refresh_q   <= '0;
            simple_q    <= 1'b0;
            frame_pad_q <= 1'b0;
            dbl_q       <= 1'b0;
            done_o      <= 1'b0;
            rate_khz_o  <= '0;
        end else begin
            mul_go <= 1'b0;
            div_go <= 1'b0;
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        lanes_q     <= (lanes_i == 3'd0) ? 3'd1 : lanes_i;
                        refresh_q   <= refresh_i;
                        simple_q    <= simple_i;
                        frame_pad_q <= eotp_i && ((vmode_i == VM_SYNC_PULSE) ||
                                                  (vmode_i == VM_SYNC_EVENT));
                        dbl_q       <= line_pad_w;
                        mul_go      <= 1'b1;
                        if (simple_i) begin
                            mul_a <= WIDE_W'(pclk_khz_i);
                            mul_b <= BW'(bpp_w);
                            state <= ST_PMUL;
                        end else begin
                            mul_a <= WIDE_W'(line_bytes);
                            mul_b <= BW'(vlines);
                            state <= ST_FRAME;
                        end
                    end
                end
                ST_FRAME: begin
                    if (mul_done) begin
                        mul_a  <= mul_p + (frame_pad_q ? WIDE_W'(EOT_PAD_BYTES) : '0);
                        mul_b  <= BW'(refresh_q);
                        mul_go <= 1'b1;
                        state  <= ST_RATE;
                    end
                end
                ST_RATE: begin
                    if (mul_done) begin
                        div_n  <= mul_p;
                        div_d  <= BW'(lanes_q);
                        div_go <= 1'b1;
                        state  <= ST_LANE;
                    end
                end
                ST_LANE: begin
                    if (div_done) begin
                        div_n  <= div_q << 3;
                        div_d  <= BW'(1000);
                        div_go <= 1'b1;
                        state  <= ST_KHZ;
                    end
                end
                ST_KHZ: begin
                    if (div_done) begin
                        rate_khz_o <= sat_to_res(dbl_q ? (div_q << 1) : div_q);
                        done_o     <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                ST_PMUL: begin
                    if (mul_done) begin
                        div_n  <= mul_p + WIDE_W'(lanes_q >> 1);
                        div_d  <= BW'(lanes_q);
                        div_go <= 1'b1;
                        state  <= ST_PDIV;
                    end
                end
                ST_PDIV: begin
                    if (div_done) begin
                        rate_khz_o <= sat_to_res(div_q);
                        done_o     <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rate_khz_o));

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(lanes_q) && $stable(refresh_q) && $stable(simple_q))));

    assert_lane_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (lanes_q != 3'd0));

    assert_mul_issue_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> !mul_busy);

    assert_div_issue_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !div_busy);

endmodule

// File: tb/sim_dsi_link_rate_calc.sv
module sim_dsi_link_rate_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        simple_i = 1'b0;
    logic [2:0]  fmt_i = '0;
    logic [1:0]  vmode_i = '0;
    logic        eotp_i = 1'b0;
    logic [2:0]  lanes_i = 3'd1;
    logic [7:0]  refresh_i = '0;
    logic [31:0] pclk_khz_i = '0;
    logic [15:0] h_act_i = '0, h_fp_i = '0, h_sync_i = '0, h_bp_i = '0;
    logic [15:0] v_act_i = '0, v_fp_i = '0, v_sync_i = '0, v_bp_i = '0;
    logic        busy_o, done_o;
    logic [31:0] rate_khz_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dsi_link_rate_calc u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .simple_i(simple_i),
        .fmt_i(fmt_i), .vmode_i(vmode_i), .eotp_i(eotp_i), .lanes_i(lanes_i),
        .refresh_i(refresh_i), .pclk_khz_i(pclk_khz_i),
        .h_act_i(h_act_i), .h_fp_i(h_fp_i), .h_sync_i(h_sync_i), .h_bp_i(h_bp_i),
        .v_act_i(v_act_i), .v_fp_i(v_fp_i), .v_sync_i(v_sync_i), .v_bp_i(v_bp_i),
        .busy_o(busy_o), .done_o(done_o), .rate_khz_o(rate_khz_o)
    );

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: code 1 -> 18, code 3 -> 16, everything else -> 24
    function automatic longint unsigned bpp_m(input logic [2:0] f);
        if (f == 3'd1) return 18;
        if (f == 3'd3) return 16;
        return 24;
    endfunction

    function automatic longint unsigned ceil_bytes(input logic [15:0] px, input longint unsigned b);
        return (longint'(px) * b + 7) / 8;
    endfunction

    // Expected result from the requirements, using the current input values
    function automatic longint unsigned model();
        longint unsigned b, ln, line, frame, r;
        b  = bpp_m(fmt_i);
        ln = (lanes_i == 3'd0) ? 1 : longint'(lanes_i);
        if (simple_i) begin
            r = (longint'(pclk_khz_i) * b + ln / 2) / ln;
        end else begin
            line = 32 + ceil_bytes(h_sync_i, b) + ceil_bytes(h_bp_i, b)
                      + ceil_bytes(h_act_i, b) + ceil_bytes(h_fp_i, b);
            if (vmode_i == 2'd2 && eotp_i) line += 4;
            frame = line * (longint'(v_act_i) + longint'(v_fp_i) + longint'(v_sync_i) + longint'(v_bp_i));
            if (vmode_i < 2'd2 && eotp_i) frame += 4;
            r = longint'(refresh_i) * frame;
            r = r / ln;
            r = r * 8;
            r = r / 1000;
            if (vmode_i == 2'd2 && eotp_i) r = r * 2;
        end
        if (r > 64'hFFFF_FFFF) r = 64'hFFFF_FFFF;
        return r;
    endfunction

    // Launch one operation, optionally poke a second start while busy, check result
    task automatic run_op(input string req, input bit poke);
        longint unsigned exp;
        int waitc;
        exp = model();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1;
            lanes_i = (lanes_i == 3'd4) ? 3'd1 : lanes_i + 3'd1;
            fmt_i   = fmt_i + 3'd1;
            refresh_i = refresh_i + 8'd7;
            simple_i = ~simple_i;
            @(negedge clk);
            start_i = 1'b0;
        end
        waitc = 0;
        while (!done_o && waitc < 1000) begin
            @(negedge clk);
            waitc++;
        end
        if (!done_o) begin
            chk(1'b0, {req, " timeout"}, waitc, 1000);
        end else begin
            chk(rate_khz_o == exp[31:0], req, rate_khz_o, exp);
            chk(busy_o == 1'b0, "R10 idle at done", busy_o, 0);
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single pulse", done_o, 0);
        chk(busy_o == 1'b0, "R11 no restart from ignored start", busy_o, 0);
    endtask

    task automatic set_timing(input int ha, hf, hs, hb, va, vf, vs, vb);
        h_act_i = 16'(ha); h_fp_i = 16'(hf); h_sync_i = 16'(hs); h_bp_i = 16'(hb);
        v_act_i = 16'(va); v_fp_i = 16'(vf); v_sync_i = 16'(vs); v_bp_i = 16'(vb);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy_o == 1'b0, "R12 busy in reset", busy_o, 0);
        chk(done_o == 1'b0, "R12 done in reset", done_o, 0);
        chk(rate_khz_o == 32'd0, "R12 result in reset", rate_khz_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && rate_khz_o == 32'd0, "R12 after reset", rate_khz_o, 0);

        // R1 R7: every format code in simple mode, one lane
        simple_i = 1'b1; lanes_i = 3'd1; pclk_khz_i = 32'd1000;
        for (int f = 0; f < 8; f++) begin
            fmt_i = 3'(f);
            run_op("R1 bpp by format code", 1'b0);
        end
        // R7: rounding to nearest, halves up
        pclk_khz_i = 32'd5; fmt_i = 3'd3; lanes_i = 3'd3;
        run_op("R7 round 80/3", 1'b0);
        pclk_khz_i = 32'd1; fmt_i = 3'd1; lanes_i = 3'd4;
        run_op("R7 round half up 18/4", 1'b0);
        // R8: zero lanes acts as one
        pclk_khz_i = 32'd148500; fmt_i = 3'd0; lanes_i = 3'd0;
        run_op("R8 lane zero simple", 1'b0);
        // R9: saturation in simple mode
        pclk_khz_i = 32'hFFFF_FFFF; lanes_i = 3'd1;
        run_op("R9 saturate simple", 1'b0);

        // R2 R3: ceil per region at 18 bpp, no padding mode
        simple_i = 1'b0; fmt_i = 3'd1; vmode_i = 2'd3; eotp_i = 1'b1;
        lanes_i = 3'd1; refresh_i = 8'd125;
        set_timing(1, 1, 1, 1, 1, 0, 0, 0);
        run_op("R2 R3 region ceil and overhead", 1'b0);
        set_timing(3, 5, 7, 9, 2, 1, 1, 1);
        run_op("R2 odd region widths", 1'b0);

        // R4: burst with and without end packets
        set_timing(1080, 48, 32, 80, 1920, 3, 5, 23);
        fmt_i = 3'd0; refresh_i = 8'd60; lanes_i = 3'd4; vmode_i = 2'd2;
        eotp_i = 1'b1;
        run_op("R4 burst with end packet", 1'b0);
        eotp_i = 1'b0;
        run_op("R4 burst without end packet", 1'b0);
        // R5: per-frame padding for modes 0 and 1, none for 3
        eotp_i = 1'b1; vmode_i = 2'd0; lanes_i = 3'd3;
        run_op("R5 sync pulse frame pad", 1'b0);
        vmode_i = 2'd1; set_timing(2, 0, 0, 0, 1, 0, 0, 0); refresh_i = 8'd200; lanes_i = 3'd1;
        run_op("R5 sync event frame pad", 1'b0);
        vmode_i = 2'd3;
        run_op("R5 plain mode no pad", 1'b0);
        // R8: zero lanes in timing mode
        lanes_i = 3'd0; set_timing(800, 40, 10, 40, 480, 10, 2, 20); vmode_i = 2'd0;
        run_op("R8 lane zero timing", 1'b0);
        // R9: saturation in timing mode, largest timings
        set_timing(65535, 65535, 65535, 65535, 65535, 65535, 65535, 65535);
        refresh_i = 8'd255; lanes_i = 3'd1; vmode_i = 2'd2; eotp_i = 1'b1;
        run_op("R9 saturate timing", 1'b0);
        // R11: start while busy ignored, both modes
        set_timing(720, 20, 8, 30, 1280, 12, 4, 16); refresh_i = 8'd60;
        lanes_i = 3'd2; vmode_i = 2'd0; fmt_i = 3'd0;
        run_op("R11 start ignored timing", 1'b1);
        simple_i = 1'b1; pclk_khz_i = 32'd74250; lanes_i = 3'd3; fmt_i = 3'd3;
        run_op("R11 start ignored simple", 1'b1);

        // R6: random timings and settings
        for (int k = 0; k < 40; k++) begin
            simple_i   = ($urandom_range(0, 3) == 0);
            fmt_i      = 3'($urandom_range(0, 7));
            vmode_i    = 2'($urandom_range(0, 3));
            eotp_i     = 1'($urandom_range(0, 1));
            lanes_i    = 3'($urandom_range(1, 4));
            refresh_i  = 8'($urandom_range(1, 120));
            pclk_khz_i = $urandom_range(1000, 600000);
            set_timing($urandom_range(0, 2600), $urandom_range(0, 200), $urandom_range(0, 100),
                       $urandom_range(0, 200), $urandom_range(0, 1600), $urandom_range(0, 40),
                       $urandom_range(0, 10), $urandom_range(0, 40));
            run_op("R6 random", 1'b0);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule